// File: doc/BRIEF.md
# Cursor position shifter

This block keeps the horizontal position of a hardware cursor together with one 16-pixel row of its bitmap. From them it prepares what a later scanline stage needs: the bitmap row moved to its pixel offset inside a 32-bit window, and the index of the 16-pixel word in a 1024-pixel line where that window starts. The position is held in reversed form, so the pixel column is 1023 minus the stored value.

Software first loads the position and the bitmap row over the shared bus, each with its own strobe. When the cursor task signals that it is blocking, the block computes the window and the word index from the values it holds at that moment. The same strobe also withdraws the cursor wakeup request. The request is raised again by a pulse at the end of horizontal sync.

Top module: `cursor_pos_shifter`

## Requirements
- R1: After reset the position, bitmap, shifted window, word index and wakeup flag all read zero.
- R2: A position-load strobe writes bus[9:0] (the low ten bits) into the position register. Bus bits 15:10 have no effect.
- R3: A bitmap-load strobe writes all 16 bus bits into the bitmap register.
- R4: On a block strobe the word index becomes (1023 - position) / 16, a value from 0 to 63.
- R5: On a block strobe the 32-bit window becomes the bitmap, zero-extended to 32 bits and shifted left by 16 - ((1023 - position) mod 16). The shift therefore runs from 1 to 16 places, and bits that leave the low half land in the high half.
- R6: The window and the word index change only on a block strobe. Loads of the position or the bitmap leave them unchanged.
- R7: A block strobe uses the register values held before the clock edge, even when a load strobe arrives in the same cycle. The load still takes effect.
- R8: An end-of-sync pulse sets the wakeup flag. The flag stays set until a block strobe arrives.
- R9: A block strobe without an end-of-sync pulse clears the wakeup flag.
- R10: When an end-of-sync pulse and a block strobe fall in the same cycle, the wakeup flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 16 | Data bus |
| ld_pos_i | input | 1 | Load the position from the bus |
| ld_map_i | input | 1 | Load the bitmap row from the bus |
| blk_i | input | 1 | Cursor task block strobe |
| hs_end_i | input | 1 | End-of-horizontal-sync pulse |
| pos_o | output | 10 | Stored (reversed) position |
| map_o | output | 16 | Stored bitmap row |
| shifted_o | output | 32 | Shifted cursor window |
| word_idx_o | output | 6 | Index of the first destination word |
| wake_o | output | 1 | Cursor wakeup flag |

## Verification
Two pairs of events can land in the same cycle. In the first, a block strobe meets a load strobe. The bench raises both on the same edge and expects the window to be built from the old position or bitmap, while the register still takes the new value. In the second, a block strobe meets an end-of-sync pulse. The bench drives both together and expects the wakeup flag to be set afterwards, and it also checks that a block strobe on its own clears the flag.

// File: rtl/cpos_pkg.sv
package cpos_pkg;
  localparam int unsigned CPOS_POS_W  = 10;
  localparam int unsigned CPOS_DATA_W = 16;
endpackage

// File: rtl/cpos_regs.sv
module cpos_regs #(
  parameter int unsigned POS_W  = cpos_pkg::CPOS_POS_W,
  parameter int unsigned DATA_W = cpos_pkg::CPOS_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus,
  input  logic              ld_pos,
  input  logic              ld_map,
  output logic [POS_W-1:0]  pos_q,
  output logic [DATA_W-1:0] map_q
);
  logic [POS_W-1:0]  pos_d;
  logic [DATA_W-1:0] map_d;

  always_comb begin
    pos_d = pos_q;
    map_d = map_q;
    if (ld_pos) pos_d = bus[POS_W-1:0];
    if (ld_map) map_d = bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      map_q <= '0;
    end else begin
      if (ld_pos) pos_q <= pos_d;
      if (ld_map) map_q <= map_d;
    end
  end

  // R2: load takes the low bus bits; otherwise the position holds
  p_pos_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pos |=> pos_q == $past(bus[POS_W-1:0]));
  p_pos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_pos |=> $stable(pos_q));
  // R3
  p_map_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_map |=> map_q == $past(bus));
endmodule

// File: rtl/cpos_shift.sv
module cpos_shift #(
  parameter int unsigned POS_W  = cpos_pkg::CPOS_POS_W,
  parameter int unsigned DATA_W = cpos_pkg::CPOS_DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk,
  input  logic [POS_W-1:0]    pos,
  input  logic [DATA_W-1:0]   map,
  output logic [2*DATA_W-1:0] shifted_q,
  output logic [POS_W-$clog2(DATA_W)-1:0] idx_q
);
  localparam int unsigned LSB_W = $clog2(DATA_W);
  localparam int unsigned IDX_W = POS_W - LSB_W;
  localparam int unsigned SH_W  = LSB_W + 1;

  logic [POS_W-1:0]    col;
  logic [LSB_W-1:0]    frac;
  logic [SH_W-1:0]     amt;
  logic [2*DATA_W-1:0] shifted_d;
  logic [IDX_W-1:0]    idx_d;

  always_comb begin
    col       = ~pos;  // all-ones minus stored value
    frac      = col[LSB_W-1:0];
    amt       = SH_W'(DATA_W) - SH_W'(frac);
    shifted_d = {{DATA_W{1'b0}}, map} << amt;
    idx_d     = col[POS_W-1:LSB_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifted_q <= '0;
      idx_q     <= '0;
    end else if (blk) begin
      shifted_q <= shifted_d;
      idx_q     <= idx_d;
    end
  end

  // R6: outputs move only on a block strobe
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !blk |=> $stable(shifted_q) && $stable(idx_q));
  // R5: shifting keeps every bitmap bit (shift never exceeds DATA_W)
  p_bits_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> $countones(shifted_q) == $countones($past(map)));
  // R5: the lowest window bit is always shifted in as zero
  p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> shifted_q[0] == 1'b0);
endmodule

// File: rtl/cpos_wake.sv
module cpos_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;  // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  // R8 / R10
  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  // R9
  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !flag_q);
  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i && !clr_i |=> $stable(flag_q));
endmodule

// File: rtl/cursor_pos_shifter.sv
module cursor_pos_shifter #(
  parameter int unsigned POS_W  = cpos_pkg::CPOS_POS_W,
  parameter int unsigned DATA_W = cpos_pkg::CPOS_DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   bus_i,
  input  logic                ld_pos_i,
  input  logic                ld_map_i,
  input  logic                blk_i,
  input  logic                hs_end_i,
  output logic [POS_W-1:0]    pos_o,
  output logic [DATA_W-1:0]   map_o,
  output logic [2*DATA_W-1:0] shifted_o,
  output logic [POS_W-$clog2(DATA_W)-1:0] word_idx_o,
  output logic                wake_o
);
  cpos_regs #(.POS_W(POS_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus(bus_i), .ld_pos(ld_pos_i),
    .ld_map(ld_map_i), .pos_q(pos_o), .map_q(map_o));

  cpos_shift #(.POS_W(POS_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .blk(blk_i), .pos(pos_o), .map(map_o),
    .shifted_q(shifted_o), .idx_q(word_idx_o));

  cpos_wake u_wake (
    .clk(clk), .rst_n(rst_n), .set_i(hs_end_i), .clr_i(blk_i),
    .flag_q(wake_o));

  // R7: a block strobe sees the position held before a same-cycle load
  p_old_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_i && ld_pos_i |=> word_idx_o == ~$past(pos_o[POS_W-1:$clog2(DATA_W)]));
endmodule

// File: tb/cursor_pos_shifter_bench.sv
module cursor_pos_shifter_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_i;
  logic        ld_pos_i, ld_map_i, blk_i, hs_end_i;
  logic [9:0]  pos_o;
  logic [15:0] map_o;
  logic [31:0] shifted_o;
  logic [5:0]  word_idx_o;
  logic        wake_o;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  cursor_pos_shifter u_cursor_pos_shifter (
    .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .ld_pos_i(ld_pos_i),
    .ld_map_i(ld_map_i), .blk_i(blk_i), .hs_end_i(hs_end_i),
    .pos_o(pos_o), .map_o(map_o), .shifted_o(shifted_o),
    .word_idx_o(word_idx_o), .wake_o(wake_o));

  function automatic logic [31:0] exp_win(input int p, input int m);
    int x;
    x = 1023 - p;
    return 32'(m) << (16 - (x % 16));
  endfunction

  function automatic int exp_idx(input int p);
    return (1023 - p) / 16;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one edge, then release all strobes at the following falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    ld_pos_i = 0; ld_map_i = 0; blk_i = 0; hs_end_i = 0;
  endtask

  task automatic load(input logic pos, input logic [15:0] v);
    bus_i = v;
    if (pos) ld_pos_i = 1; else ld_map_i = 1;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 pos", 32'(pos_o), 0);
    chk("R1 map", 32'(map_o), 0);
    chk("R1 win", shifted_o, 0);
    chk("R1 idx", 32'(word_idx_o), 0);
    chk("R1 wake", 32'(wake_o), 0);
  endtask

  task automatic t_loads();
    load(1'b1, 16'hFC05);  // upper bits must be dropped
    chk("R2 pos masked", 32'(pos_o), 32'h005);
    load(1'b0, 16'hA5C3);
    chk("R3 map", 32'(map_o), 32'hA5C3);
    chk("R6 win after loads", shifted_o, 0);
    chk("R6 idx after loads", 32'(word_idx_o), 0);
  endtask

  task automatic t_block(input int p, input int m);
    load(1'b1, 16'(p));
    load(1'b0, 16'(m));
    blk_i = 1;
    tick();
    chk($sformatf("R4 idx p=%0d", p), 32'(word_idx_o), 32'(exp_idx(p)));
    chk($sformatf("R5 win p=%0d", p), shifted_o, exp_win(p, m));
  endtask

  task automatic t_hold();
    logic [31:0] w;
    w = shifted_o;
    load(1'b1, 16'd300);
    load(1'b0, 16'h1234);
    chk("R6 win held", shifted_o, w);
  endtask

  task automatic t_same_cycle();
    // pos currently 300, map 1234
    bus_i = 16'd7; ld_pos_i = 1; blk_i = 1;
    tick();
    chk("R7 idx old pos", 32'(word_idx_o), 32'(exp_idx(300)));
    chk("R7 win old pos", shifted_o, exp_win(300, 16'h1234));
    chk("R7 pos loaded", 32'(pos_o), 7);
    bus_i = 16'hFFFF; ld_map_i = 1; blk_i = 1;
    tick();
    chk("R7 win old map", shifted_o, exp_win(7, 16'h1234));
    chk("R7 map loaded", 32'(map_o), 32'hFFFF);
  endtask

  task automatic t_wake();
    hs_end_i = 1; tick();
    chk("R8 set", 32'(wake_o), 1);
    tick(); tick();
    chk("R8 held", 32'(wake_o), 1);
    blk_i = 1; tick();
    chk("R9 cleared", 32'(wake_o), 0);
    blk_i = 1; hs_end_i = 1; tick();
    chk("R10 set wins", 32'(wake_o), 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; bus_i = 0;
    ld_pos_i = 0; ld_map_i = 0; blk_i = 0; hs_end_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_loads();
    t_block(1023, 16'h8001);  // column 0: shift 16, word 0
    t_block(0, 16'hFFFF);     // column 1023: shift 1, word 63
    t_block(1008, 16'hC003);  // column 15: shift 1, word 0
    t_block(513, 16'h00F0);   // column 510: shift 2, word 31
    t_hold();
    t_same_cycle();
    t_wake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule